// File: doc/BRIEF.md
# Dual-Precision IEEE Rounding Unit

This unit turns an unrounded floating-point intermediate into a finished double-format result. Each operand arrives as a sign, a 12-bit two's-complement unbiased exponent and a 56-bit mantissa. The top bit of the mantissa is the integer bit and must be set unless the mantissa is zero. Below it lie 52 fraction bits and three extra bits that hold guard, round and sticky information. A 2-bit mode input selects one of four IEEE rounding directions. A precision bit from configuration selects single or double. A per-operation override can replace that bit for one operation only.

Both precisions share one datapath. In double precision the unit keeps 53 significant bits. In single precision it keeps 24 and folds every bit below the single round position into sticky. A single-rounded result is still emitted in double layout: its exponent is range-checked against single bounds and then re-biased into the 11-bit double field. If the rounding increment carries out of the kept significand, the result is renormalised. Results above the range saturate to infinity or to the largest finite value, depending on the mode and the sign. Results below the range flush to a signed zero. A flag reports each of these two cases.

The result is registered and appears one clock after the operand is presented with `in_valid`.

Top module: `fpr_round_unit`

## Requirements
- R1: A result appears on the outputs, with `out_valid` high, in the cycle after `in_valid` is sampled high. `out_valid` is low in the cycle after `in_valid` is sampled low.
- R2: The effective precision is `ovr_single` when `ovr_en` is 1, and `cfg_single` otherwise. A value of 1 means single and 0 means double.
- R3: Mode encoding is 00 nearest-even, 01 toward zero, 10 toward minus infinity and 11 toward plus infinity. Toward zero never increments. Toward minus infinity increments the magnitude only for a negative sign when any discarded bit is set. Toward plus infinity does the same only for a positive sign.
- R4: In nearest-even, the magnitude is incremented when guard is set and at least one of round, sticky or the kept lsb is set. An exact tie with an even lsb is left unchanged.
- R5: In double precision, the kept significand is mantissa bits 55..3. Guard is bit 2, round is bit 1 and sticky is bit 0. The output fraction is the low 52 bits of the rounded significand.
- R6: In single precision, the kept significand is mantissa bits 55..32. Guard is bit 31, round is bit 30 and sticky is the OR of bits 29..0. The output fraction is the 23 rounded fraction bits in fraction bits 51..29, with bits 28..0 zero.
- R7: When the increment carries out of the kept significand, the significand is shifted right by one and the exponent is incremented.
- R8: For an in-range result, the exponent field is the rounded exponent plus 1023. A zero mantissa gives exponent field 0 and fraction 0 with the input sign, and sets no flag.
- R9: A rounded exponent above 1023 (double) or above 127 (single) sets `out_ovf`. The output is infinity (exponent 2047, fraction 0) in nearest mode, and in a directed mode whose direction matches the sign. Otherwise it is the largest finite value: exponent 2046 with all-ones fraction in double, or exponent 1150 with fraction bits 51..29 set in single.
- R10: A rounded exponent below -1022 (double) or below -126 (single) sets `out_unf` and outputs zero with the input sign. `out_ovf` and `out_unf` are never both set.
- R11: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Operand sign |
| in_exp | input | 12 | Unbiased two's-complement exponent |
| in_mant | input | 56 | Integer bit, 52 fraction bits, guard, round, sticky |
| rmode | input | 2 | Rounding mode |
| cfg_single | input | 1 | Configured precision (1 = single) |
| ovr_en | input | 1 | Per-operation precision override enable |
| ovr_single | input | 1 | Override precision (1 = single) |
| out_valid | output | 1 | Result valid |
| out_sign | output | 1 | Result sign |
| out_exp | output | 11 | Biased exponent field |
| out_frac | output | 52 | Fraction field |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |

## Verification
Every result and both flags are due exactly one rising edge after the operand is presented. No output depends on an earlier operand. The bench drives each operand on a falling edge, so the rising edge that follows captures it. It then compares all outputs at the next falling edge against a reference that it computes with integer shift-and-compare arithmetic. After a run of operands, the bench leaves one cycle idle and checks that `out_valid` drops at the same one-cycle spacing.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int MANT_W   = 56;
  localparam int EXP_W    = 12;
  localparam int WEXP_W   = EXP_W + 1;
  localparam int OEXP_W   = 11;
  localparam int FRAC_W   = 52;
  localparam int DBL_KEEP = FRAC_W + 1;
  localparam int SGL_KEEP = 24;
  localparam int BIAS     = 1023;
  localparam int DBL_EMAX = 1023;
  localparam int DBL_EMIN = -1022;
  localparam int SGL_EMAX = 127;
  localparam int SGL_EMIN = -126;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_DOWN = 2'b10,
    RND_UP   = 2'b11
  } rnd_mode_e;

  // Decide whether the magnitude is bumped by one unit in the last place.
  function automatic logic round_up(rnd_mode_e m, logic s, logic lsb,
                                    logic g, logic r, logic st);
    logic lost;
    lost = g | r | st;
    case (m)
      RND_NEAR: return g & (r | st | lsb);
      RND_ZERO: return 1'b0;
      RND_DOWN: return s & lost;
      default:  return ~s & lost;
    endcase
  endfunction

  // Overflow goes to infinity when rounding may move away from zero.
  function automatic logic ovf_to_inf(rnd_mode_e m, logic s);
    case (m)
      RND_NEAR: return 1'b1;
      RND_ZERO: return 1'b0;
      RND_DOWN: return s;
      default:  return ~s;
    endcase
  endfunction
endpackage

// File: rtl/fpr_prec_sel.sv
module fpr_prec_sel (
  input  logic cfg_single,
  input  logic ovr_en,
  input  logic ovr_single,
  output logic use_single
);
  assign use_single = ovr_en ? ovr_single : cfg_single;
endmodule

// File: rtl/fpr_round_core.sv
module fpr_round_core
  import fpr_pkg::*;
(
  input  logic                     single,
  input  rnd_mode_e                mode,
  input  logic                     sign,
  input  logic [EXP_W-1:0]         exp_i,
  input  logic [MANT_W-1:0]        mant_i,
  output logic [DBL_KEEP-1:0]      sig_o,
  output logic signed [WEXP_W-1:0] exp_o,
  output logic                     inc_o,
  output logic                     carry_o
);
  localparam int SGL_SH = MANT_W - SGL_KEEP;
  localparam int DBL_SH = MANT_W - DBL_KEEP;

  logic [DBL_KEEP-1:0] kept;
  logic                lsb, gbit, rbit, sbit;
  logic [DBL_KEEP:0]   sum;

  // The lsb, guard, round and sticky positions move with the precision.
  always_comb begin
    if (single) begin
      kept = {{(DBL_KEEP-SGL_KEEP){1'b0}}, mant_i[MANT_W-1 -: SGL_KEEP]};
      lsb  = mant_i[SGL_SH];
      gbit = mant_i[SGL_SH-1];
      rbit = mant_i[SGL_SH-2];
      sbit = |mant_i[SGL_SH-3:0];
    end else begin
      kept = mant_i[MANT_W-1 -: DBL_KEEP];
      lsb  = mant_i[DBL_SH];
      gbit = mant_i[DBL_SH-1];
      rbit = mant_i[DBL_SH-2];
      sbit = |mant_i[DBL_SH-3:0];
    end
  end

  assign inc_o   = round_up(mode, sign, lsb, gbit, rbit, sbit);
  assign sum     = {1'b0, kept} + {{DBL_KEEP{1'b0}}, inc_o};
  assign carry_o = single ? sum[SGL_KEEP] : sum[DBL_KEEP];
  assign sig_o   = carry_o ? sum[DBL_KEEP:1] : sum[DBL_KEEP-1:0];
  assign exp_o   = $signed({exp_i[EXP_W-1], exp_i})
                 + $signed({{(WEXP_W-1){1'b0}}, carry_o});
endmodule

// File: rtl/fpr_range_pack.sv
module fpr_range_pack
  import fpr_pkg::*;
(
  input  logic                     single,
  input  rnd_mode_e                mode,
  input  logic                     sign,
  input  logic                     is_zero,
  input  logic [DBL_KEEP-1:0]      sig_i,
  input  logic signed [WEXP_W-1:0] wexp_i,
  output logic [OEXP_W-1:0]        exp_f,
  output logic [FRAC_W-1:0]        frac_f,
  output logic                     ovf,
  output logic                     unf
);
  localparam int PAD_W = FRAC_W - SGL_KEEP + 1;
  localparam logic signed [WEXP_W-1:0] BIAS_W = WEXP_W'(BIAS);

  logic signed [WEXP_W-1:0] emax, emin;
  logic [FRAC_W-1:0]        frac_norm, frac_max;

  assign emax      = single ? WEXP_W'(SGL_EMAX) : WEXP_W'(DBL_EMAX);
  assign emin      = single ? WEXP_W'(SGL_EMIN) : WEXP_W'(DBL_EMIN);
  assign frac_norm = single ? {sig_i[SGL_KEEP-2:0], {PAD_W{1'b0}}}
                            : sig_i[FRAC_W-1:0];
  assign frac_max  = single ? {{(SGL_KEEP-1){1'b1}}, {PAD_W{1'b0}}}
                            : {FRAC_W{1'b1}};

  always_comb begin
    ovf    = 1'b0;
    unf    = 1'b0;
    exp_f  = OEXP_W'(wexp_i + BIAS_W);
    frac_f = frac_norm;
    if (is_zero) begin
      exp_f  = '0;
      frac_f = '0;
    end else if (wexp_i > emax) begin
      ovf = 1'b1;
      if (ovf_to_inf(mode, sign)) begin
        exp_f  = '1;
        frac_f = '0;
      end else begin
        exp_f  = OEXP_W'(emax + BIAS_W);
        frac_f = frac_max;
      end
    end else if (wexp_i < emin) begin
      unf    = 1'b1;
      exp_f  = '0;
      frac_f = '0;
    end
  end
endmodule

// File: rtl/fpr_round_unit.sv
module fpr_round_unit
  import fpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic [1:0]        rmode,
  input  logic              cfg_single,
  input  logic              ovr_en,
  input  logic              ovr_single,
  output logic              out_valid,
  output logic              out_sign,
  output logic [OEXP_W-1:0] out_exp,
  output logic [FRAC_W-1:0] out_frac,
  output logic              out_ovf,
  output logic              out_unf
);
  rnd_mode_e                mode_w;
  logic                     use_single;
  logic [DBL_KEEP-1:0]      sig_w;
  logic signed [WEXP_W-1:0] wexp_w;
  logic                     inc_w, carry_w, ovf_w, unf_w;
  logic [OEXP_W-1:0]        exp_w;
  logic [FRAC_W-1:0]        frac_w;

  assign mode_w = rnd_mode_e'(rmode);

  fpr_prec_sel u_prec (
    .cfg_single (cfg_single),
    .ovr_en     (ovr_en),
    .ovr_single (ovr_single),
    .use_single (use_single)
  );

  fpr_round_core u_core (
    .single  (use_single),
    .mode    (mode_w),
    .sign    (in_sign),
    .exp_i   (in_exp),
    .mant_i  (in_mant),
    .sig_o   (sig_w),
    .exp_o   (wexp_w),
    .inc_o   (inc_w),
    .carry_o (carry_w)
  );

  fpr_range_pack u_pack (
    .single  (use_single),
    .mode    (mode_w),
    .sign    (in_sign),
    .is_zero (in_mant == '0),
    .sig_i   (sig_w),
    .wexp_i  (wexp_w),
    .exp_f   (exp_w),
    .frac_f  (frac_w),
    .ovf     (ovf_w),
    .unf     (unf_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sign  <= 1'b0;
      out_exp   <= '0;
      out_frac  <= '0;
      out_ovf   <= 1'b0;
      out_unf   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign <= in_sign;
        out_exp  <= exp_w;
        out_frac <= frac_w;
        out_ovf  <= ovf_w;
        out_unf  <= unf_w;
      end
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_rz_no_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_w == RND_ZERO) |-> !inc_w);
  assert_carry_needs_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && carry_w) |-> inc_w);
  assert_single_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && use_single) |=> (out_frac[FRAC_W-SGL_KEEP:0] == '0));
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_ovf && out_unf));
  assert_unf_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_unf |-> (out_exp == '0 && out_frac == '0));
  assert_ovf_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |-> ((out_exp == '1 && out_frac == '0) ||
                 out_exp == OEXP_W'(DBL_EMAX + BIAS) ||
                 out_exp == OEXP_W'(SGL_EMAX + BIAS)));
endmodule

// File: tb/fpr_round_unit_bench.sv
`timescale 1ns/1ps
module fpr_round_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sign = 1'b0;
  logic [11:0] in_exp = '0;
  logic [55:0] in_mant = '0;
  logic [1:0]  rmode = '0;
  logic        cfg_single = 1'b0, ovr_en = 1'b0, ovr_single = 1'b0;
  logic        out_valid, out_sign, out_ovf, out_unf;
  logic [10:0] out_exp;
  logic [51:0] out_frac;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fpr_round_unit u_fpr_round_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_mant(in_mant), .rmode(rmode),
    .cfg_single(cfg_single), .ovr_en(ovr_en), .ovr_single(ovr_single),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_frac(out_frac), .out_ovf(out_ovf), .out_unf(out_unf)
  );

  // Reference: {ovf, unf, sign, exp[10:0], frac[51:0]}
  function automatic logic [65:0] ref_round(logic s, logic [11:0] e,
      logic [55:0] m, logic [1:0] md, logic sgl);
    int sh, kw, ex, emax, emin;
    logic [63:0] mm, kept, rem, half;
    logic up, inf;
    logic [51:0] fr;
    if (m == '0) return {2'b00, s, 63'd0};
    mm   = {8'd0, m};
    sh   = sgl ? 32 : 3;
    kw   = sgl ? 24 : 53;
    kept = mm >> sh;
    rem  = mm & ((64'd1 << sh) - 64'd1);
    half = 64'd1 << (sh - 1);
    case (md)
      2'b00:   up = (rem > half) || (rem == half && kept[0]);
      2'b01:   up = 1'b0;
      2'b10:   up = s && rem != 0;
      default: up = !s && rem != 0;
    endcase
    ex = int'($signed(e));
    kept = kept + {63'd0, up};
    if ((kept >> kw) != 0) begin
      kept = kept >> 1;
      ex = ex + 1;
    end
    emax = sgl ? 127 : 1023;
    emin = sgl ? -126 : -1022;
    if (ex > emax) begin
      inf = (md == 2'b00) || (md == 2'b11 && !s) || (md == 2'b10 && s);
      if (inf) return {2'b10, s, 11'h7FF, 52'd0};
      fr = sgl ? {23'h7FFFFF, 29'd0} : {52{1'b1}};
      return {2'b10, s, 11'(emax + 1023), fr};
    end
    if (ex < emin) return {2'b01, s, 63'd0};
    fr = sgl ? {kept[22:0], 29'd0} : kept[51:0];
    return {2'b00, s, 11'(ex + 1023), fr};
  endfunction

  task automatic check(string req, logic [65:0] act, logic [65:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp_v);
    end
  endtask

  // Drive on a falling edge; the next rising edge captures; compare on the
  // following falling edge.
  task automatic run(string req, logic s, int e, logic [55:0] m,
      logic [1:0] md, logic cfg, logic oen, logic osg);
    logic sgl;
    logic [65:0] exp_v;
    in_valid = 1'b1; in_sign = s; in_exp = 12'(e); in_mant = m;
    rmode = md; cfg_single = cfg; ovr_en = oen; ovr_single = osg;
    sgl   = oen ? osg : cfg;
    exp_v = ref_round(s, 12'(e), m, md, sgl);
    @(negedge clk);
    check("R1", {65'd0, out_valid}, 66'd1);
    check(req, {out_ovf, out_unf, out_sign, out_exp, out_frac}, exp_v);
  endtask

  localparam logic [55:0] ONE   = 56'h80000000000000;
  localparam logic [55:0] TIE_E = 56'h80000000000004;
  localparam logic [55:0] TIE_O = 56'h8000000000000C;
  localparam logic [55:0] SGL_S = 56'h80000080000001;
  localparam logic [55:0] ALL1  = 56'hFFFFFFFFFFFFFF;

  initial begin
    int edges[8] = '{-1023, -1022, -127, -126, 126, 127, 1022, 1023};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R11", {out_valid, out_ovf, out_unf, out_sign, out_exp, out_frac}, 67'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run("R5",  1'b0, 0,     ONE,   2'b00, 1'b0, 1'b0, 1'b0);
    run("R4",  1'b0, 5,     TIE_E, 2'b00, 1'b0, 1'b0, 1'b0);
    run("R4",  1'b1, 5,     TIE_O, 2'b00, 1'b0, 1'b0, 1'b0);
    run("R6",  1'b0, 3,     SGL_S, 2'b00, 1'b1, 1'b0, 1'b0);
    run("R5",  1'b0, 3,     SGL_S, 2'b00, 1'b0, 1'b0, 1'b0);
    run("R3",  1'b0, 3,     SGL_S, 2'b01, 1'b1, 1'b0, 1'b0);
    run("R3",  1'b0, 3,     SGL_S, 2'b10, 1'b1, 1'b0, 1'b0);
    run("R3",  1'b1, 3,     SGL_S, 2'b10, 1'b1, 1'b0, 1'b0);
    run("R3",  1'b0, 3,     SGL_S, 2'b11, 1'b1, 1'b0, 1'b0);
    run("R3",  1'b1, 3,     SGL_S, 2'b11, 1'b1, 1'b0, 1'b0);
    run("R7",  1'b0, 10,    ALL1,  2'b00, 1'b0, 1'b0, 1'b0);
    run("R7",  1'b1, -10,   ALL1,  2'b00, 1'b1, 1'b0, 1'b0);
    run("R9",  1'b0, 1023,  ALL1,  2'b00, 1'b0, 1'b0, 1'b0);
    run("R9",  1'b0, 1023,  ALL1,  2'b01, 1'b0, 1'b0, 1'b0);
    run("R9",  1'b0, 127,   ALL1,  2'b10, 1'b1, 1'b0, 1'b0);
    run("R9",  1'b1, 127,   ALL1,  2'b11, 1'b1, 1'b0, 1'b0);
    run("R9",  1'b1, 200,   ONE,   2'b10, 1'b1, 1'b0, 1'b0);
    run("R10", 1'b0, -1023, ONE,   2'b00, 1'b0, 1'b0, 1'b0);
    run("R10", 1'b1, -127,  ONE,   2'b11, 1'b1, 1'b0, 1'b0);
    run("R10", 1'b0, -126,  ONE,   2'b00, 1'b1, 1'b0, 1'b0);
    run("R2",  1'b0, 3,     SGL_S, 2'b00, 1'b0, 1'b1, 1'b1);
    run("R2",  1'b0, 3,     SGL_S, 2'b00, 1'b1, 1'b1, 1'b0);
    run("R8",  1'b1, 77,    56'd0, 2'b11, 1'b0, 1'b0, 1'b0);
    run("R8",  1'b0, -1022, ONE,   2'b00, 1'b0, 1'b0, 1'b0);
    // idle cycle: out_valid must drop (R1)
    in_valid = 1'b0;
    @(negedge clk);
    check("R1", {65'd0, out_valid}, 66'd0);
    // constrained random mix covering R3 R4 R5 R6 R7 R8 R9 R10 R2
    for (int i = 0; i < 600; i++) begin
      logic [55:0] m;
      int e;
      m = {1'b1, 23'($urandom), $urandom};
      if ($urandom % 5 == 0) m[31:0] = ($urandom % 2) ? 32'h80000000 : 32'hFFFFFFFF;
      if ($urandom % 6 == 0) m[2:0] = 3'($urandom % 8);
      if ($urandom % 20 == 0) m = '0;
      if ($urandom % 4 == 0) e = edges[$urandom % 8];
      else e = int'($urandom % 2200) - 1100;
      run("R3-mix", 1'($urandom), e, m, 2'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom));
    end
    in_valid = 1'b0;
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule